// File: doc/BRIEF.md
# DSP Exception Vectoring Controller

This block sequences exceptions and interrupts for a small 16-bit DSP core. Eight exception levels can be raised at any time. Each raised level is latched in a pending register. At every instruction boundary, which the core marks with a step strobe, the block looks for the most important pending level that is allowed through. If it finds one, the program counter goes to that level's vector in the same cycle. The interrupted PC and the status word are saved on two small hardware stacks.

A signed register records the level now being served, and holds -1 when no exception is active. New entries are accepted only while that value is below one. A level-0 handler can therefore still be interrupted, but a higher active level blocks all further entries. A return-from-interrupt strobe pops the saved PC and status word and marks the block idle again.

The block owns a control word. Its mailbox-request bit is turned into the external-interrupt level whenever the status word allows it. The completion of an instruction-memory DMA load raises the reset level.

Top module: `dsp_exc_seq`

## Requirements
- R1: A high bit n on `raise_i` sets pending bit n on the next clock edge. A pending bit stays set until its level is taken, and taking a level clears only that level's bit.
- R2: Among the levels that are pending and allowed through, the one with the highest number is taken.
- R3: When status bit 9 (global enable) is 0, only the reset level (0) and the external-interrupt level (7) can be taken. Other pending levels stay pending.
- R4: When level i is taken, `taken_o` is high and `pc_o` equals 2·i in the step cycle. The current `pc_i` and `sr_i` are pushed onto their stacks.
- R5: `active_o` reads -1 after reset and after a return. After level i is taken, it reads i.
- R6: With `active_o` greater than 0, no level is taken. With `active_o` equal to 0 or -1, levels are taken.
- R7: On `rti_i`, `pc_o` shows the most recently saved PC, and `sr_load_o` is high with `sr_o` showing the saved status word. `rti_i` takes precedence over a step in the same cycle.
- R8: Suppose control bit 1 is set, status bit 11 (external enable) is 1, and `active_o` is below 1. Then control bit 1 clears and pending bit 7 sets. Otherwise control bit 1 stays set. A write through `ctl_wr_i` wins over this clear.
- R9: After reset the control word reads 0x0804, nothing is pending, both stacks are empty, and both stack flags are low.
- R10: A pulse on `dma_done_i` sets pending bit 0.
- R11: A push onto a full stack is dropped and sets the sticky `stk_ovf_o`. A pop from an empty stack returns 0 and sets the sticky `stk_unf_o`.
- R12: In a cycle where no level is taken and `rti_i` is low, `pc_o` equals `pc_next_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| raise_i | input | 8 | Per-level exception raise requests |
| dma_done_i | input | 1 | Instruction-memory DMA load finished |
| step_i | input | 1 | Instruction boundary strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 16 | PC of the interrupted instruction stream |
| pc_next_i | input | 16 | PC the core would load without an exception |
| sr_i | input | 16 | Current status word |
| ctl_wr_i | input | 1 | Control word write enable |
| ctl_wdata_i | input | 16 | Control word write data |
| pc_o | output | 16 | PC to load this cycle |
| taken_o | output | 1 | An exception is entered this cycle |
| sr_load_o | output | 1 | Status word restore this cycle |
| sr_o | output | 16 | Status word to restore |
| pending_o | output | 8 | Pending level register |
| active_o | output | 4 | Signed level in progress, -1 when idle |
| ctl_rdata_o | output | 16 | Control word |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| stk_unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The assertions check these properties on every cycle:
- a pending bit never disappears without an entry;
- no entry occurs while a level above zero is in progress;
- the recorded level matches the vector just issued;
- every return leaves the block idle;
- entries with global enable clear go only to the reset or external vector;
- a cleared mailbox bit is followed by a pending external level.

The bench's scenarios are needed for the rest, because only a cycle model can predict it:
- the highest-first choice among several pending levels;
- the exact saved PC and status word that come back on a return;
- nested level-0 entries that fill the stacks until they overflow;
- extra returns that underflow them;
- the mailbox request that waits while external enable is clear.

// File: rtl/dsp_exc_pkg.sv
package dsp_exc_pkg;
   typedef enum logic [1:0] {
      SEQ_RUN    = 2'd0,
      SEQ_ENTER  = 2'd1,
      SEQ_RETURN = 2'd2
   } seq_op_e;
endpackage

// File: rtl/exc_pending.sv
module exc_pending #(
   parameter int NLEV = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NLEV-1:0] set_i,
   input  logic [NLEV-1:0] clr_i,
   output logic [NLEV-1:0] pend_o
);
   logic [NLEV-1:0] pend_q;

   // a new raise wins over the clear of the same level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
   parameter int NLEV      = 8,
   parameter bit SCAN_DOWN = 1'b1
) (
   input  logic [NLEV-1:0]         req_i,
   output logic                    hit_o,
   output logic [$clog2(NLEV)-1:0] lvl_o
);
   localparam int LW = $clog2(NLEV);

   assign hit_o = |req_i;

   generate
      if (SCAN_DOWN) begin : g_high_first
         always_comb begin
            lvl_o = '0;
            for (int i = 0; i < NLEV; i++)
               if (req_i[i]) lvl_o = LW'(i);
         end
      end else begin : g_low_first
         always_comb begin
            lvl_o = '0;
            for (int i = NLEV - 1; i >= 0; i--)
               if (req_i[i]) lvl_o = LW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/exc_stack.sv
module exc_stack #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] top_o,
   output logic         ovf_o,
   output logic         unf_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("exc_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [IW-1:0] top_idx;
   logic          full, empty;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign top_idx = cnt_q[IW-1:0] - 1'b1;
   assign top_o   = empty ? '0 : mem[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else if (push_i) begin
         if (full) ovf_o <= 1'b1;
         else      cnt_q <= cnt_q + 1'b1;
      end else if (pop_i) begin
         if (empty) unf_o <= 1'b1;
         else       cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !full) mem[cnt_q[IW-1:0]] <= din_i;
   end
endmodule

// File: rtl/dsp_exc_seq.sv
module dsp_exc_seq #(
   parameter int          NLEV        = 8,
   parameter int          PC_W        = 16,
   parameter int          SR_W        = 16,
   parameter int          CTL_W       = 16,
   parameter int          STK_DEPTH   = 4,
   parameter int          RST_LEV     = 0,
   parameter int          EXT_LEV     = 7,
   parameter int          IE_BIT      = 9,
   parameter int          EIE_BIT     = 11,
   parameter int          CTL_EXT_BIT = 1,
   parameter logic [15:0] CTL_INIT    = 16'h0804,
   parameter bit          SCAN_DOWN   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NLEV-1:0]             raise_i,
   input  logic                        dma_done_i,
   input  logic                        step_i,
   input  logic                        rti_i,
   input  logic [PC_W-1:0]             pc_i,
   input  logic [PC_W-1:0]             pc_next_i,
   input  logic [SR_W-1:0]             sr_i,
   input  logic                        ctl_wr_i,
   input  logic [CTL_W-1:0]            ctl_wdata_i,
   output logic [PC_W-1:0]             pc_o,
   output logic                        taken_o,
   output logic                        sr_load_o,
   output logic [SR_W-1:0]             sr_o,
   output logic [NLEV-1:0]             pending_o,
   output logic signed [$clog2(NLEV):0] active_o,
   output logic [CTL_W-1:0]            ctl_rdata_o,
   output logic                        stk_ovf_o,
   output logic                        stk_unf_o
);
   import dsp_exc_pkg::*;

   localparam int LW = $clog2(NLEV);
   localparam int AW = LW + 1;
   localparam logic signed [AW-1:0] ACT_IDLE = -1;
   localparam logic signed [AW-1:0] ACT_ONE  = 1;
   localparam logic [NLEV-1:0] BYPASS = (NLEV'(1) << RST_LEV) | (NLEV'(1) << EXT_LEV);

   generate
      if (RST_LEV >= NLEV || EXT_LEV >= NLEV) begin : g_bad_lev
         $error("dsp_exc_seq: fixed levels out of range");
      end
      if (IE_BIT >= SR_W || EIE_BIT >= SR_W || CTL_EXT_BIT >= CTL_W) begin : g_bad_bit
         $error("dsp_exc_seq: enable bit position out of range");
      end
      if (PC_W < LW + 1) begin : g_bad_pc
         $error("dsp_exc_seq: PC too narrow for vectors");
      end
   endgenerate

   logic [NLEV-1:0]        pend, eligible, set_vec, clr_vec;
   logic                   hit, allow, ext_fire;
   logic [LW-1:0]          lvl;
   logic signed [AW-1:0]   act_q;
   logic [CTL_W-1:0]       ctl_q;
   logic [PC_W-1:0]        pc_top;
   logic [SR_W-1:0]        sr_top;
   logic                   ovf_pc, ovf_sr, unf_pc, unf_sr;
   seq_op_e                op;

   assign allow    = (act_q < ACT_ONE);
   assign eligible = pend & (sr_i[IE_BIT] ? {NLEV{1'b1}} : BYPASS);

   exc_pick #(.NLEV(NLEV), .SCAN_DOWN(SCAN_DOWN)) u_pick (
      .req_i (eligible),
      .hit_o (hit),
      .lvl_o (lvl)
   );

   always_comb begin
      if (rti_i)                        op = SEQ_RETURN;
      else if (step_i && allow && hit)  op = SEQ_ENTER;
      else                              op = SEQ_RUN;
   end

   assign ext_fire = ctl_q[CTL_EXT_BIT] && sr_i[EIE_BIT] && allow;

   always_comb begin
      set_vec = raise_i;
      if (dma_done_i) set_vec[RST_LEV] = 1'b1;
      if (ext_fire)   set_vec[EXT_LEV] = 1'b1;
      clr_vec = '0;
      if (op == SEQ_ENTER) clr_vec[lvl] = 1'b1;
   end

   exc_pending #(.NLEV(NLEV)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .pend_o (pend)
   );

   exc_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_pc_stk (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (op == SEQ_ENTER),
      .pop_i  (op == SEQ_RETURN),
      .din_i  (pc_i),
      .top_o  (pc_top),
      .ovf_o  (ovf_pc),
      .unf_o  (unf_pc)
   );

   exc_stack #(.W(SR_W), .DEPTH(STK_DEPTH)) u_sr_stk (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (op == SEQ_ENTER),
      .pop_i  (op == SEQ_RETURN),
      .din_i  (sr_i),
      .top_o  (sr_top),
      .ovf_o  (ovf_sr),
      .unf_o  (unf_sr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= ACT_IDLE;
         ctl_q <= CTL_W'(CTL_INIT);
      end else begin
         case (op)
            SEQ_RETURN: act_q <= ACT_IDLE;
            SEQ_ENTER:  act_q <= $signed({1'b0, lvl});
            default:    act_q <= act_q;
         endcase
         if (ctl_wr_i)      ctl_q <= ctl_wdata_i;
         else if (ext_fire) ctl_q[CTL_EXT_BIT] <= 1'b0;
      end
   end

   always_comb begin
      case (op)
         SEQ_ENTER:  pc_o = PC_W'(lvl) << 1;
         SEQ_RETURN: pc_o = pc_top;
         default:    pc_o = pc_next_i;
      endcase
   end

   assign taken_o     = (op == SEQ_ENTER);
   assign sr_load_o   = (op == SEQ_RETURN);
   assign sr_o        = sr_top;
   assign pending_o   = pend;
   assign active_o    = act_q;
   assign ctl_rdata_o = ctl_q;
   assign stk_ovf_o   = ovf_pc | ovf_sr;
   assign stk_unf_o   = unf_pc | unf_sr;
endmodule

// File: rtl/dsp_exc_seq_chk.sv
module dsp_exc_seq_chk #(
   parameter int NLEV        = 8,
   parameter int PC_W        = 16,
   parameter int SR_W        = 16,
   parameter int CTL_W       = 16,
   parameter int RST_LEV     = 0,
   parameter int EXT_LEV     = 7,
   parameter int IE_BIT      = 9,
   parameter int CTL_EXT_BIT = 1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         step_i,
   input logic                         rti_i,
   input logic [SR_W-1:0]              sr_i,
   input logic                         ctl_wr_i,
   input logic [PC_W-1:0]              pc_o,
   input logic                         taken_o,
   input logic [NLEV-1:0]              pending_o,
   input logic signed [$clog2(NLEV):0] active_o,
   input logic [CTL_W-1:0]             ctl_rdata_o
);
   // R1
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |=> (($past(pending_o) & ~pending_o) == '0));

   // R6
   entry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !rti_i && active_o > 0) |-> !taken_o);

   // R4
   vec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |=> (PC_W'(active_o) == ($past(pc_o) >> 1)));

   // R5
   idle_after_rti_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rti_i |=> (active_o == -1));

   // R3
   masked_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_o && !sr_i[IE_BIT]) |->
         (pc_o == PC_W'(2 * RST_LEV) || pc_o == PC_W'(2 * EXT_LEV)));

   // R8
   ext_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctl_wr_i) && $fell(ctl_rdata_o[CTL_EXT_BIT])) |-> pending_o[EXT_LEV]);
endmodule

bind dsp_exc_seq dsp_exc_seq_chk #(
   .NLEV(NLEV), .PC_W(PC_W), .SR_W(SR_W), .CTL_W(CTL_W),
   .RST_LEV(RST_LEV), .EXT_LEV(EXT_LEV), .IE_BIT(IE_BIT), .CTL_EXT_BIT(CTL_EXT_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .rti_i(rti_i), .sr_i(sr_i),
   .ctl_wr_i(ctl_wr_i), .pc_o(pc_o), .taken_o(taken_o), .pending_o(pending_o),
   .active_o(active_o), .ctl_rdata_o(ctl_rdata_o)
);

// File: tb/sim_dsp_exc_seq.sv
module sim_dsp_exc_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  raise = '0;
   logic        dma = 1'b0, step = 1'b0, rti = 1'b0, wr = 1'b0;
   logic [15:0] pc = '0, pcn = '0, sr = '0, wdata = '0;
   logic [15:0] pc_o, sr_o, ctl_o;
   logic        taken_o, sr_load_o, ovf_o, unf_o;
   logic [7:0]  pend_o;
   logic signed [3:0] act_o;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   int m_pend = 0, m_act = -1, m_ctl = 16'h0804;
   bit m_ovf = 0, m_unf = 0;
   int pcq[$], srq[$];

   always #2.5 clk = ~clk;

   dsp_exc_seq u0 (
      .clk(clk), .rst_n(rst_n), .raise_i(raise), .dma_done_i(dma), .step_i(step),
      .rti_i(rti), .pc_i(pc), .pc_next_i(pcn), .sr_i(sr), .ctl_wr_i(wr),
      .ctl_wdata_i(wdata), .pc_o(pc_o), .taken_o(taken_o), .sr_load_o(sr_load_o),
      .sr_o(sr_o), .pending_o(pend_o), .active_o(act_o), .ctl_rdata_o(ctl_o),
      .stk_ovf_o(ovf_o), .stk_unf_o(unf_o)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      int lv, msk, epc;
      bit allow, tk, fire;
      #1;
      allow = (m_act < 1);
      msk = m_pend & (sr[9] ? 8'hFF : 8'h81);            // R3 bypass levels 0 and 7
      lv = -1;
      for (int i = 7; i >= 0; i--) if (lv < 0 && msk[i]) lv = i;   // R2
      tk = step && !rti && allow && (lv >= 0);           // R6
      if (tk)       epc = lv * 2;                        // R4
      else if (rti) epc = (pcq.size() > 0) ? pcq[$] : 0; // R7
      else          epc = pcn;                           // R12
      chk("R4", "pc_o", pc_o, epc);
      chk("R6", "taken_o", taken_o, tk);
      chk("R7", "sr_load_o", sr_load_o, rti);
      if (rti) chk("R7", "sr_o", sr_o, (srq.size() > 0) ? srq[$] : 0);
      chk("R1", "pending_o", pend_o, m_pend);
      chk("R5", "active_o", act_o, m_act);
      chk("R8", "ctl", ctl_o, m_ctl);
      chk("R11", "ovf", ovf_o, m_ovf);
      chk("R11", "unf", unf_o, m_unf);
      fire = m_ctl[1] && sr[11] && allow;
      @(posedge clk);
      if (rti) begin
         if (pcq.size() > 0) begin void'(pcq.pop_back()); void'(srq.pop_back()); end
         else m_unf = 1;
         m_act = -1;
      end else if (tk) begin
         if (pcq.size() < 4) begin pcq.push_back(pc); srq.push_back(sr); end
         else m_ovf = 1;
         m_act = lv;
         m_pend = m_pend & ~(1 << lv);
      end
      m_pend = m_pend | raise | (dma ? 1 : 0) | (fire ? 8'h80 : 0);  // R10
      if (wr) m_ctl = wdata;
      else if (fire) m_ctl = m_ctl & ~2;
      @(negedge clk);
      pcn = pcn + 16'd3;
      pc  = pc + 16'd5;
   endtask

   task automatic idle(); raise = '0; dma = 0; step = 0; rti = 0; wr = 0; endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      pcn = 16'h0100; pc = 16'h0400;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      #1;
      chk("R9", "ctl reset", ctl_o, 16'h0804);
      chk("R9", "pending reset", pend_o, 0);
      chk("R9", "flags reset", {ovf_o, unf_o}, 0);
      chk("R5", "active reset", act_o, -1);
      @(negedge clk);
      // R3: masked levels stay pending with global enable clear
      raise = 8'h28; tick(); idle();
      step = 1; tick(); tick();
      // R2: enable set, level 5 first
      sr = 16'h0200; tick();
      // R6: higher active blocks, raise 6
      step = 0; raise = 8'h40; tick(); raise = '0;
      step = 1; tick(); tick();
      // R7 return
      step = 0; sr = 16'h0000; rti = 1; tick(); rti = 0;
      sr = 16'h0200; step = 1; tick();
      step = 0; rti = 1; tick(); rti = 0;
      step = 1; tick();
      // rti and step together: return wins (R7)
      raise = 8'h04; tick(); raise = '0;
      rti = 1; tick(); rti = 0;
      tick(); step = 0; rti = 1; tick(); rti = 0;
      // R3: bypass level 7 beats level 4 with enable clear
      sr = 16'h0000; raise = 8'h90; tick(); raise = '0;
      step = 1; tick(); step = 0; rti = 1; tick(); rti = 0;
      sr = 16'h0200; step = 1; tick(); step = 0; rti = 1; tick(); rti = 0;
      // R10 + R11: level 0 nests until the stacks overflow
      sr = 16'h0000;
      for (int k = 0; k < 6; k++) begin
         dma = 1; step = 0; tick(); dma = 0;
         step = 1; tick();
      end
      step = 0;
      for (int k = 0; k < 6; k++) begin rti = 1; tick(); end
      rti = 0; tick();
      // R8: request waits while external enable clear
      wr = 1; wdata = 16'h0806; tick(); wr = 0;
      tick(); tick();
      sr = 16'h0800; tick(); tick();
      sr = 16'h0000; step = 1; tick(); step = 0; tick();
      // R8: blocked while a high level is active
      wr = 1; wdata = 16'h0002; tick(); wr = 0;
      sr = 16'h0A00; tick(); tick();
      rti = 1; tick(); rti = 0; tick();
      // R8: write wins over clear
      wr = 1; wdata = 16'h0002; tick(); tick(); wr = 0; tick();
      // R12 plain flow
      sr = 16'h0000; step = 1; tick(); tick(); step = 0; rti = 1; tick(); rti = 0;
      tick(); tick();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule